// File: doc/BRIEF.md
# Crosspoint Programming Sequencer

This block sits in a host FPGA and programs one or more serially controlled analog crosspoint switches. On a start pulse it latches the requested update, lowers the select line, sends a gated burst of serial clock pulses that carries the update least significant bit first, and raises select again. It then commits the shifted data to the switch matrix with a configure pulse. Busy is high for the whole sequence, and done pulses once at its end.

Two update kinds are supported. A full-frame update carries 16 bits per device, and devices on a daisy chain receive their frames back to back. An addressed update rewrites a single output with a 6-bit word. The configure line can be wired on its own (4-wire) or joined to the select line (3-wire). In the 3-wire case, stopping the clock frames the data and the rising select line also commits it.

Serial clock half-period and select setup are parameters counted in system clock cycles. The burst always starts and ends with the serial clock low.

Top module: `xpt_prog_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, cfg is 0, busy is 0 and done is 0.
- R2: cs_n is low for at least SETUP system cycles before the first sclk rising edge. sclk is low whenever cs_n changes level.
- R3: sclk high and low phases each last HALF system cycles. sdo changes only together with an sclk rising edge, so it is stable across every falling edge.
- R4: In full-frame mode (addr_mode=0), each device frame is 16 bits sent bit 0 first. Frame bits [4k+2:4k] hold the input address for output k, and bit 4k+3 is the off flag (1 = output off).
- R5: With n_dev devices chained, exactly 16*n_dev bits are sent. The frame in frames[16d+15:16d] belongs to device d, and the highest-numbered device's frame is sent first. n_dev=0 is treated as 1, and values above MAX_DEV are treated as MAX_DEV.
- R6: In addressed mode (addr_mode=1), exactly 6 bits are sent, bit 0 first. Bits 1:0 are the output address, bits 4:2 are the input address and bit 5 is the off flag.
- R7: In addressed mode, exactly one sclk rising edge follows the rise of cs_n. In full-frame mode no sclk edge occurs while cs_n is high.
- R8: With three_wire=0, cfg stays low while cs_n is low. It then gives one high pulse after cs_n has risen and after all bits have been sent.
- R9: With three_wire=1, cfg carries the same level as cs_n throughout the sequence.
- R10: done is high for exactly one cycle, after the commit (the cfg pulse in 4-wire) has ended. busy is high from the cycle after start until done, and falls right after done.
- R11: A start pulse while busy is ignored. The burst in progress is unchanged, and only one done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming sequence (ignored while busy) |
| addr_mode | input | 1 | 1 = addressed single-output update, 0 = full frame |
| three_wire | input | 1 | 1 = configure joined to select |
| n_dev | input | $clog2(MAX_DEV+1) | Number of chained devices for full frame |
| frames | input | 16*MAX_DEV | Full-frame settings, 16 bits per device |
| upd_out | input | 2 | Output index for addressed update |
| upd_in | input | 3 | Input index for addressed update |
| upd_off | input | 1 | Off flag for addressed update |
| sclk | output | 1 | Serial clock to devices |
| cs_n | output | 1 | Active-low select (joined line in 3-wire) |
| sdo | output | 1 | Serial data to devices |
| cfg | output | 1 | Configure/commit strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the edge ordering: select against the clock, data stability across clock high phases, configure never overlapping an active select, and the shape of done and busy. Only the bench scenarios can show the bit order itself: the chained frame order, the addressed word layout, the exact bit count, the single trailing edge in addressed mode, and that a start pulse during a run leaves the stream unchanged. A scoreboard compares each captured falling-edge bit against the queue the driver computed from the requirements.

// File: rtl/xpt_prog_seq.sv
module xpt_prog_seq #(
  parameter int MAX_DEV = 4,
  parameter int HALF    = 2,
  parameter int SETUP   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           addr_mode,
  input  logic                           three_wire,
  input  logic [$clog2(MAX_DEV+1)-1:0]   n_dev,
  input  logic [16*MAX_DEV-1:0]          frames,
  input  logic [1:0]                     upd_out,
  input  logic [2:0]                     upd_in,
  input  logic                           upd_off,
  output logic                           sclk,
  output logic                           cs_n,
  output logic                           sdo,
  output logic                           cfg,
  output logic                           busy,
  output logic                           done
);
  localparam int FW   = 16 * MAX_DEV;
  localparam int NW   = $clog2(MAX_DEV + 1);
  localparam int CW   = $clog2(FW + 1);
  localparam int TMAX = (HALF > SETUP) ? HALF : SETUP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] H1 = TW'(HALF - 1);

  typedef enum logic [3:0] {IDLE, SEL, HI, LO, DESEL, T_HI, T_LO, CMT, FIN} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [CW-1:0]  cnt;
  logic [FW-1:0]  sh, stream;
  logic [NW-1:0]  n_eff;
  logic           am, w3, cfg_r;

  assign n_eff = (n_dev == '0) ? NW'(1) : (int'(n_dev) > MAX_DEV) ? NW'(MAX_DEV) : n_dev;

  always_comb begin
    stream = '0;
    if (addr_mode) stream[5:0] = {upd_off, upd_in, upd_out};
    else
      for (int k = 0; k < MAX_DEV; k++)
        if (k < int'(n_eff)) stream[16*k +: 16] = frames[16*(int'(n_eff)-1-k) +: 16];
  end

  assign sdo  = sh[0];
  assign cfg  = w3 ? cs_n : cfg_r;
  assign busy = (st != IDLE);
  assign done = (st == FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; cnt <= '0; sh <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; cfg_r <= 1'b0; am <= 1'b0; w3 <= 1'b0;
    end else if (st != IDLE && st != FIN && tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else begin
      case (st)
        IDLE: if (start) begin
          sh   <= stream;
          cnt  <= addr_mode ? CW'(6) : CW'(16 * int'(n_eff));
          am   <= addr_mode;
          w3   <= three_wire;
          cs_n <= 1'b0;
          tmr  <= TW'(SETUP - 1);
          st   <= SEL;
        end
        SEL: begin sclk <= 1'b1; tmr <= H1; st <= HI; end
        HI:  begin sclk <= 1'b0; tmr <= H1; st <= LO; end
        LO: begin
          sh  <= sh >> 1;
          cnt <= cnt - 1'b1;
          tmr <= H1;
          if (cnt == CW'(1)) begin cs_n <= 1'b1; st <= DESEL; end
          else begin sclk <= 1'b1; st <= HI; end
        end
        DESEL: begin
          tmr <= H1;
          if (am) begin sclk <= 1'b1; st <= T_HI; end
          else if (w3) st <= FIN;
          else begin cfg_r <= 1'b1; st <= CMT; end
        end
        T_HI: begin sclk <= 1'b0; tmr <= H1; st <= T_LO; end
        T_LO: begin
          tmr <= H1;
          if (w3) st <= FIN;
          else begin cfg_r <= 1'b1; st <= CMT; end
        end
        CMT: begin cfg_r <= 1'b0; st <= FIN; end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module xpt_prog_seq_chk (
  input logic clk, rst_n, start, sclk, cs_n, sdo, cfg, busy, done
);
  a_r2_select_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !cs_n) |-> $past(!cs_n));
  a_r2_clk_low_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) || $fell(cs_n)) |-> !sclk);
  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
  a_r3_data_stable_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo));
  a_r8_cfg_not_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg && !cs_n));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
  a_r7_edges_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(busy));
endmodule

bind xpt_prog_seq xpt_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .cs_n(cs_n),
  .sdo(sdo), .cfg(cfg), .busy(busy), .done(done)
);

// File: tb/test_xpt_prog_seq.sv
`timescale 1ns/1ps
module test_xpt_prog_seq;
  localparam int MAX_DEV = 4, HALF = 2, SETUP = 3;
  localparam int FW = 16 * MAX_DEV;

  logic clk = 0, rst_n = 0, start = 0, addr_mode = 0, three_wire = 0, upd_off = 0;
  logic [2:0] n_dev = 1;
  logic [FW-1:0] frames = '0;
  logic [1:0] upd_out = 0;
  logic [2:0] upd_in = 0;
  logic sclk, cs_n, sdo, cfg, busy, done;

  always #2 clk = ~clk;

  xpt_prog_seq #(.MAX_DEV(MAX_DEV), .HALF(HALF), .SETUP(SETUP)) i_xpt_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_mode(addr_mode), .three_wire(three_wire),
    .n_dev(n_dev), .frames(frames), .upd_out(upd_out), .upd_in(upd_in), .upd_off(upd_off),
    .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .cfg(cfg), .busy(busy), .done(done));

  int checks = 0, fails = 0;
  bit exp_q[$];
  string cur_req = "R4";
  int bit_idx, setup_len, hi_len, hi_bad, sdo_bad, sel_bad, tail_rises, cfg_rises;
  int cfg_early, mirror_bad, done_cnt, extra_bits;
  bit seen_rise, cfg_fell_seen, done_after_cfg;
  logic p_sclk = 0, p_csn = 1, p_cfg = 0, p_sdo = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    exp_q.delete();
    bit_idx = 0; setup_len = 0; hi_len = 0; hi_bad = 0; sdo_bad = 0; sel_bad = 0;
    tail_rises = 0; cfg_rises = 0; cfg_early = 0; mirror_bad = 0; done_cnt = 0;
    extra_bits = 0; seen_rise = 0; cfg_fell_seen = 0; done_after_cfg = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && !sclk && !seen_rise) setup_len++;
      if (sclk && !p_sclk) begin
        if (!cs_n && !seen_rise) seen_rise = 1;
        if (cs_n) tail_rises++;
      end
      if (sclk) hi_len++;
      if (!sclk && p_sclk) begin
        if (hi_len != HALF) hi_bad++;
        hi_len = 0;
        if (!cs_n) begin
          if (exp_q.size() == 0) extra_bits++;
          else begin
            automatic bit e = exp_q.pop_front();
            checks++;
            if (sdo !== e) begin
              fails++;
              $display("FAIL %s bit %0d actual=%0d expected=%0d", cur_req, bit_idx, sdo, e);
            end
            bit_idx++;
          end
        end
      end
      if (sclk && p_sclk && sdo !== p_sdo) sdo_bad++;
      if (cs_n !== p_csn && sclk) sel_bad++;
      if (cfg && !p_cfg) begin
        cfg_rises++;
        if (exp_q.size() != 0) cfg_early++;
      end
      if (!cfg && p_cfg) cfg_fell_seen = 1;
      if (busy && cfg !== cs_n) mirror_bad++;
      if (done) begin
        done_cnt++;
        done_after_cfg = cfg_fell_seen;
      end
    end
    p_sclk = sclk; p_csn = cs_n; p_cfg = cfg; p_sdo = sdo;
  end

  task automatic run(input bit am, input bit w3, input int nd, input logic [FW-1:0] fr,
                     input logic [1:0] o, input logic [2:0] in_a, input bit off, input bit poke,
                     input string req);
    int ne;
    @(posedge clk); #1;
    clear_stats();
    cur_req = req;
    addr_mode = am; three_wire = w3; n_dev = 3'(nd); frames = fr;
    upd_out = o; upd_in = in_a; upd_off = off;
    if (am) begin
      exp_q.push_back(o[0]); exp_q.push_back(o[1]);
      for (int b = 0; b < 3; b++) exp_q.push_back(in_a[b]);
      exp_q.push_back(off);
    end else begin
      ne = (nd == 0) ? 1 : (nd > MAX_DEV ? MAX_DEV : nd);
      for (int d = ne - 1; d >= 0; d--)
        for (int b = 0; b < 16; b++) exp_q.push_back(fr[16*d + b]);
    end
    start = 1;
    @(posedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (12) @(posedge clk); #1;
      frames = ~fr; addr_mode = ~am; n_dev = 3'd2; start = 1;
      @(posedge clk); #1;
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && extra_bits == 0, {req, " bit count (R5/R6 length)"}, exp_q.size() + extra_bits, 0);
    chk(setup_len >= SETUP, "R2 select setup", setup_len, SETUP);
    chk(sel_bad == 0, "R2 sclk low at select change", sel_bad, 0);
    chk(hi_bad == 0 && sdo_bad == 0, "R3 phase width and data stability", hi_bad + sdo_bad, 0);
    chk(tail_rises == (am ? 1 : 0), "R7 trailing edges", tail_rises, am ? 1 : 0);
    if (!w3) begin
      chk(cfg_rises == 1 && cfg_early == 0, "R8 single late cfg pulse", cfg_rises * 10 + cfg_early, 10);
      chk(done_after_cfg, "R10 done after cfg pulse ends", done_after_cfg, 1);
    end else begin
      chk(mirror_bad == 0, "R9 cfg follows joined select", mirror_bad, 0);
    end
    chk(done_cnt == 1 && !busy, poke ? "R11 start while busy ignored" : "R10 one done then idle",
        done_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(posedge clk); #1;
    chk(cs_n === 1 && sclk === 0 && cfg === 0 && busy === 0 && done === 0,
        "R1 reset levels", {cs_n, sclk, cfg, busy, done}, 5'b10000);
    rst_n = 1;
    repeat (2) @(posedge clk);
    run(0, 0, 1, 64'h0000_0000_0000_A5C3, 0, 0, 0, 0, "R4");
    run(0, 0, 3, 64'h0000_1234_BEEF_C0DE, 0, 0, 0, 0, "R5");
    run(0, 0, 0, 64'h0000_0000_0000_7E81, 0, 0, 0, 0, "R5");
    run(0, 0, 4, 64'hF00D_8421_0F0F_3C69, 0, 0, 0, 0, "R5");
    run(1, 0, 1, '0, 2'd2, 3'd5, 0, 0, "R6");
    run(1, 1, 1, '0, 2'd3, 3'd1, 1, 0, "R6");
    run(0, 1, 2, 64'h0000_0000_9A5B_66C1, 0, 0, 0, 0, "R9");
    run(0, 0, 1, 64'h0000_0000_0000_5AA5, 0, 0, 0, 1, "R11");
    run(1, 0, 1, '0, 2'd1, 3'd6, 1, 1, "R11");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule